// File: doc/BRIEF.md
# Wiper Shadow Store and Recall Sequencer

This block holds the tap settings of a bank of digitally controlled potentiometers. Each pot has a volatile wiper register that sets the tap, and a non-volatile copy that keeps its power-on value. A serial slave sits in front of the block. For each committed data byte it gives a one-cycle write strobe with the byte's register address. When chip select goes high it gives a one-cycle end-of-transaction strobe. The non-volatile store is modelled as registers that only a cold power-on reset clears. A program cycle is timed by a counter of system clocks.

After a warm reset is released, the block copies each non-volatile value into its wiper, one pot per clock. A control register holds a program-enable bit. When that bit is set, the first wiper write of a transaction is also latched for programming. The end-of-transaction strobe then starts a program cycle of fixed length. A write-in-progress flag in the control register stays high during the whole cycle. The latched byte reaches the non-volatile copy only when the cycle ends. A host must therefore poll the flag before it reads back a stored value.

Top module: `nv_shadow_seq`

## Requirements
- R1: While `por_n` is low, every non-volatile value is set to `NV_INIT` (default 64). A low `rst_n` alone leaves those values unchanged.
- R2: `rst_n` is released through two synchronising flops. The third rising edge after release loads wiper 0 from its non-volatile value. The next three edges load wipers 1, 2 and 3 in that order. The wiper registers hold 0 before they are loaded. Control bit 5 reads 1 from reset until the last load. Write strobes are ignored until that point.
- R3: A write strobe to address 0 to 3 sets that wiper to `wr_data[6:0]` on the next clock, and bit 7 is ignored. Strobes to addresses 4 to 7 and 9 to 15 change no wiper and no control bit.
- R4: Address 8 is the control register. Bit 7 is the program enable: it is written from `wr_data[7]` and resets to 0. Bit 5 is write-in-progress and is read-only. All other bits read 0.
- R5: A program cycle starts on the clock that samples `cs_rise` high, and only if a byte was latched in that transaction. Control bit 5 then reads 1 for exactly `PROG_CYCLES` clocks.
- R6: The latched value is written into the addressed non-volatile copy on the clock that ends the cycle, and not before.
- R7: Only the first wiper write of a transaction that has the program enable set is latched. Later bytes in the same transaction update only their wipers.
- R8: While a program cycle runs, wiper writes still update the wipers. They latch nothing, and the next `cs_rise` starts no new cycle.
- R9: With the program enable clear, wiper writes update only the wipers, and `cs_rise` starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Cold power-on reset, active low; clears the non-volatile model |
| rst_n | input | 1 | Warm reset, active low; asynchronous assert, synchronous release |
| wr_stb | input | 1 | One-cycle strobe for a committed data byte |
| wr_addr | input | 4 | Register address of the committed byte |
| wr_data | input | 8 | Committed data byte |
| cs_rise | input | 1 | One-cycle strobe at the end of a transaction |
| wiper_o | output | 28 | Wiper values; pot i at bits [7i+6:7i] |
| ctrl_o | output | 8 | Control register read value (bit 7 enable, bit 5 busy) |
| nv_o | output | 28 | Non-volatile values; pot i at bits [7i+6:7i] |

## Verification
The hardest case to reach is a transaction that arrives while a program cycle is already running. Both its wiper update and its end strobe must then land inside the busy window. The stimulus starts a programming transaction, waits a few cycles, and sends a new wiper write and end strobe. It then waits well past the end of the first cycle and confirms that no second cycle began. The recall window is handled in a similar way. A warm reset is issued without a power-on reset, and a write strobe is placed on the first recall edge. The recalled values must come from the earlier programming and must not reflect that write.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 8;
  localparam int CTRL_NV_BIT  = 7;
  localparam int CTRL_WIP_BIT = 5;

  typedef enum logic {
    PH_RUN    = 1'b0,
    PH_RECALL = 1'b1
  } phase_e;

endpackage

// File: rtl/nvseq_reset_sync.sv
module nvseq_reset_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sh_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= 2'b00;
    else          sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_no = sh_q[1];

endmodule

// File: rtl/nvseq_commit.sv
module nvseq_commit
  import nvseq_pkg::*;
#(
  parameter int NUM_POTS  = 4,
  parameter int TAP_W     = 7,
  parameter int CTRL_ADDR = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         wr_stb_i,
  input  logic [ADDR_W-1:0]                            wr_addr_i,
  input  logic [DATA_W-1:0]                            wr_data_i,
  input  logic                                         cs_rise_i,
  input  logic                                         prog_busy_i,
  output logic                                         rec_busy_o,
  output logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] rec_idx_o,
  output logic                                         vol_we_o,
  output logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] vol_idx_o,
  output logic [TAP_W-1:0]                             vol_val_o,
  output logic                                         start_o,
  output logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] tgt_o,
  output logic [TAP_W-1:0]                             tval_o,
  output logic                                         nv_en_o
);

  localparam int                IDX_W    = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;
  localparam logic [ADDR_W-1:0] POT_LIM  = ADDR_W'(NUM_POTS);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_POTS - 1);

  phase_e             ph_q, ph_d;
  logic [IDX_W-1:0]   ridx_q, ridx_d;
  logic               nv_en_q, nv_en_d;
  logic               pend_q, pend_d;
  logic [IDX_W-1:0]   pidx_q;
  logic [TAP_W-1:0]   pval_q;
  logic               active, hit_pot, hit_ctrl, capture;

  // next-state
  always_comb begin
    active   = (ph_q == PH_RUN);
    hit_pot  = wr_stb_i && active && (wr_addr_i < POT_LIM);
    hit_ctrl = wr_stb_i && active && (wr_addr_i == CTRL_A);
    capture  = hit_pot && nv_en_q && !prog_busy_i && !pend_q && !cs_rise_i;

    ph_d   = ph_q;
    ridx_d = ridx_q;
    if (ph_q == PH_RECALL) begin
      ridx_d = ridx_q + 1'b1;
      if (ridx_q == LAST_IDX) begin
        ph_d   = PH_RUN;
        ridx_d = '0;
      end
    end

    nv_en_d = hit_ctrl ? wr_data_i[CTRL_NV_BIT] : nv_en_q;

    pend_d = pend_q;
    if (cs_rise_i)    pend_d = 1'b0;
    else if (capture) pend_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_RECALL;
      ridx_q  <= '0;
      nv_en_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      ridx_q  <= ridx_d;
      nv_en_q <= nv_en_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pidx_q <= '0;
      pval_q <= '0;
    end else if (capture) begin
      pidx_q <= wr_addr_i[IDX_W-1:0];
      pval_q <= wr_data_i[TAP_W-1:0];
    end
  end

  assign rec_busy_o = (ph_q == PH_RECALL);
  assign rec_idx_o  = ridx_q;
  assign vol_we_o   = hit_pot;
  assign vol_idx_o  = wr_addr_i[IDX_W-1:0];
  assign vol_val_o  = wr_data_i[TAP_W-1:0];
  assign start_o    = cs_rise_i && pend_q && active;
  assign tgt_o      = pidx_q;
  assign tval_o     = pval_q;
  assign nv_en_o    = nv_en_q;

  // A latched byte is never replaced before the transaction ends
  p_pend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cs_rise_i) |=> (pend_q && $stable(pidx_q) && $stable(pval_q)));

  // Recall walks the pots in ascending order, one per clock
  p_recall_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RECALL && ridx_q != LAST_IDX) |=>
      (ph_q == PH_RECALL && ridx_q == IDX_W'($past(ridx_q) + 1'b1)));

endmodule

// File: rtl/nvseq_nv_bank.sv
module nvseq_nv_bank #(
  parameter int NUM_POTS    = 4,
  parameter int TAP_W       = 7,
  parameter int PROG_CYCLES = 600000,
  parameter int NV_INIT     = 64
) (
  input  logic                                         clk_i,
  input  logic                                         por_ni,
  input  logic                                         rst_ni,
  input  logic                                         start_i,
  input  logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] tgt_i,
  input  logic [TAP_W-1:0]                             tval_i,
  output logic                                         busy_o,
  output logic [NUM_POTS*TAP_W-1:0]                    nv_o
);

  localparam int               IDX_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;
  localparam int               CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [TAP_W-1:0] INIT  = TAP_W'(NV_INIT);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done;

  always_comb begin
    done   = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_cell
    logic [TAP_W-1:0] cell_q;
    logic             we;
    assign we = done && (tgt_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)  cell_q <= INIT;
      else if (we)  cell_q <= tval_i;
    end
    assign nv_o[g*TAP_W +: TAP_W] = cell_q;
  end

  assign busy_o = busy_q;

  // checker: length of each busy window
  logic [CNT_W:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (start_i) len_q <= '0;
    else if (busy_q)  len_q <= len_q + 1'b1;
  end

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

  p_busy_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (len_q == (CNT_W+1)'(PROG_CYCLES)));

  p_cells_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> $stable(nv_o));

endmodule

// File: rtl/nvseq_wiper_bank.sv
module nvseq_wiper_bank #(
  parameter int NUM_POTS = 4,
  parameter int TAP_W    = 7
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         we_i,
  input  logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] idx_i,
  input  logic [TAP_W-1:0]                             val_i,
  input  logic                                         rec_en_i,
  input  logic [((NUM_POTS > 1) ? $clog2(NUM_POTS) : 1)-1:0] rec_idx_i,
  input  logic [TAP_W-1:0]                             rec_val_i,
  output logic [NUM_POTS*TAP_W-1:0]                    wiper_o
);

  localparam int IDX_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_wiper
    logic [TAP_W-1:0] w_q, w_d;

    always_comb begin
      w_d = w_q;
      if (rec_en_i && rec_idx_i == IDX_W'(g)) w_d = rec_val_i;
      else if (we_i && idx_i == IDX_W'(g))    w_d = val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else         w_q <= w_d;
    end

    assign wiper_o[g*TAP_W +: TAP_W] = w_q;
  end

  // Host writes never coincide with a recall load
  p_rec_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_en_i |-> !we_i);

  // With no write and no load, all wipers keep their value
  p_wiper_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !rec_en_i) |=> $stable(wiper_o));

endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nvseq_pkg::*;
#(
  parameter int NUM_POTS    = 4,
  parameter int TAP_W       = 7,
  parameter int CTRL_ADDR   = 8,
  parameter int PROG_CYCLES = 600000,
  parameter int NV_INIT     = 64
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      rst_n,
  input  logic                      wr_stb,
  input  logic [3:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      cs_rise,
  output logic [NUM_POTS*TAP_W-1:0] wiper_o,
  output logic [7:0]                ctrl_o,
  output logic [NUM_POTS*TAP_W-1:0] nv_o
);

  localparam int IDX_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;

  logic             rst_int, por_int;
  logic             rec_busy, vol_we, start, nv_en, prog_busy;
  logic [IDX_W-1:0] rec_idx, vol_idx, tgt;
  logic [TAP_W-1:0] vol_val, tval, rec_val;
  logic [NUM_POTS*TAP_W-1:0] nv_flat;

  nvseq_reset_sync u_rst_sync (.clk_i(clk), .arst_ni(rst_n), .rst_no(rst_int));
  nvseq_reset_sync u_por_sync (.clk_i(clk), .arst_ni(por_n), .rst_no(por_int));

  nvseq_commit #(
    .NUM_POTS(NUM_POTS), .TAP_W(TAP_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_commit (
    .clk_i(clk), .rst_ni(rst_int),
    .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cs_rise_i(cs_rise), .prog_busy_i(prog_busy),
    .rec_busy_o(rec_busy), .rec_idx_o(rec_idx),
    .vol_we_o(vol_we), .vol_idx_o(vol_idx), .vol_val_o(vol_val),
    .start_o(start), .tgt_o(tgt), .tval_o(tval), .nv_en_o(nv_en)
  );

  nvseq_nv_bank #(
    .NUM_POTS(NUM_POTS), .TAP_W(TAP_W),
    .PROG_CYCLES(PROG_CYCLES), .NV_INIT(NV_INIT)
  ) u_nv (
    .clk_i(clk), .por_ni(por_int), .rst_ni(rst_int),
    .start_i(start), .tgt_i(tgt), .tval_i(tval),
    .busy_o(prog_busy), .nv_o(nv_flat)
  );

  always_comb rec_val = nv_flat[rec_idx*TAP_W +: TAP_W];

  nvseq_wiper_bank #(
    .NUM_POTS(NUM_POTS), .TAP_W(TAP_W)
  ) u_wipers (
    .clk_i(clk), .rst_ni(rst_int),
    .we_i(vol_we), .idx_i(vol_idx), .val_i(vol_val),
    .rec_en_i(rec_busy), .rec_idx_i(rec_idx), .rec_val_i(rec_val),
    .wiper_o(wiper_o)
  );

  always_comb begin
    ctrl_o               = '0;
    ctrl_o[CTRL_NV_BIT]  = nv_en;
    ctrl_o[CTRL_WIP_BIT] = rec_busy | prog_busy;
  end

  assign nv_o = nv_flat;

endmodule

// File: tb/nv_shadow_seq_tb.sv
module nv_shadow_seq_tb;

  localparam int P = 40;

  logic clk = 1'b0;
  logic por_n, rst_n, wr_stb, cs_rise;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [27:0] wiper_o, nv_o;
  logic [7:0]  ctrl_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  nv_shadow_seq #(.PROG_CYCLES(P)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .cs_rise(cs_rise),
    .wiper_o(wiper_o), .ctrl_o(ctrl_o), .nv_o(nv_o)
  );

  function automatic int wf(int i);
    return int'(wiper_o[i*7 +: 7]);
  endfunction
  function automatic int nf(int i);
    return int'(nv_o[i*7 +: 7]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_w[4], m_nv[4];
  int m_sinc, m_ridx, m_cnt, m_pa, m_pd;
  bit m_en, m_rec, m_busy, m_pend;

  always @(posedge clk) begin
    bit hp, hc, cap, st;
    if (!por_n) for (int i = 0; i < 4; i++) m_nv[i] = 64;
    if (!rst_n || m_sinc < 2) begin
      if (!rst_n) m_sinc = 0; else m_sinc++;
      for (int i = 0; i < 4; i++) m_w[i] = 0;
      m_en = 0; m_rec = 1; m_ridx = 0; m_busy = 0; m_pend = 0; m_cnt = 0;
    end else begin
      hp  = wr_stb && !m_rec && (wr_addr < 4);
      hc  = wr_stb && !m_rec && (wr_addr == 8);
      cap = hp && m_en && !m_busy && !m_pend && !cs_rise;
      st  = cs_rise && m_pend && !m_rec;
      if (m_busy) begin
        if (m_cnt == 0) begin m_nv[m_pa] = m_pd; m_busy = 0; end
        else m_cnt--;
      end else if (st) begin
        m_busy = 1; m_cnt = P - 1;
      end
      if (m_rec) begin
        m_w[m_ridx] = m_nv[m_ridx];
        m_ridx++;
        if (m_ridx == 4) begin m_rec = 0; m_ridx = 0; end
      end
      if (hp) m_w[wr_addr] = int'(wr_data[6:0]);
      if (hc) m_en = wr_data[7];
      if (cs_rise) m_pend = 0;
      else if (cap) begin m_pend = 1; m_pa = int'(wr_addr); m_pd = int'(wr_data[6:0]); end
    end
  end

  // compare with the model every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (m_sinc > 0 || !rst_n) begin
      for (int i = 0; i < 4; i++) begin
        chk($sformatf("R3 model wiper%0d", i), wf(i), m_w[i]);
        chk($sformatf("R6 model nv%0d", i), nf(i), m_nv[i]);
      end
      chk("R5 model ctrl", int'(ctrl_o),
          (m_en ? 128 : 0) + ((m_rec || m_busy) ? 32 : 0));
    end
  end

  task automatic wr_byte(int a, int d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic pulse_cs();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic end_and_measure(output int n);
    @(negedge clk); cs_rise = 1'b1;
    @(posedge clk); #5; cs_rise = 1'b0;
    n = 0;
    while (ctrl_o[5] && n < 1000) begin
      n++;
      @(posedge clk); #5;
    end
  endtask

  initial begin
    int n;
    m_sinc = 0;
    por_n = 0; rst_n = 0; wr_stb = 0; cs_rise = 0; wr_addr = 0; wr_data = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R2 wip in reset", int'(ctrl_o), 32);
        chk("R1 nv0 at por", nf(0), 64);
        por_n = 1; rst_n = 1;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          chk("R2 recalled wiper", wf(i), 64);
          chk("R1 nv init", nf(i), 64);
        end
        chk("R4 ctrl after recall", int'(ctrl_o), 0);

        wr_byte(0, 8'h85);
        chk("R3 bit7 ignored", wf(0), 5);
        wr_byte(5, 8'h11);
        wr_byte(12, 8'hFF);
        chk("R3 unused addr", wf(1), 64);
        chk("R3 unused addr ctrl", int'(ctrl_o), 0);
        end_and_measure(n);
        chk("R9 no cycle when disabled", n, 0);
        chk("R9 nv0 kept", nf(0), 64);

        wr_byte(8, 8'hFF);
        chk("R4 only bit7 set", int'(ctrl_o), 128);
        wr_byte(8, 8'h5F);
        chk("R4 bit7 cleared", int'(ctrl_o), 0);
        wr_byte(8, 8'h80);

        wr_byte(1, 8'h22);
        wr_byte(2, 8'h33);
        wr_byte(3, 8'h44);
        chk("R6 nv1 before end", nf(1), 64);
        end_and_measure(n);
        chk("R5 busy length", n, P);
        chk("R6 nv1 programmed", nf(1), 34);
        chk("R7 nv2 untouched", nf(2), 64);
        chk("R7 nv3 untouched", nf(3), 64);
        chk("R7 wiper3 updated", wf(3), 68);

        wr_byte(2, 8'h11);
        pulse_cs();
        repeat (5) @(negedge clk);
        wr_byte(3, 8'h55);
        chk("R8 wiper during busy", wf(3), 85);
        pulse_cs();
        while (ctrl_o[5]) @(negedge clk);
        repeat (60) @(negedge clk);
        chk("R8 no second cycle", int'(ctrl_o[5]), 0);
        chk("R8 nv3 untouched", nf(3), 64);
        chk("R6 nv2 programmed", nf(2), 17);

        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        wr_stb = 1; wr_addr = 0; wr_data = 8'h01;
        @(negedge clk); wr_stb = 0;
        chk("R2 wip during recall", int'(ctrl_o[5]), 1);
        repeat (6) @(negedge clk);
        chk("R2 write in recall ignored", wf(0), 64);
        chk("R2 recall nv1", wf(1), 34);
        chk("R2 recall nv2", wf(2), 17);
        chk("R2 recall nv3", wf(3), 64);
        chk("R1 warm reset keeps nv", nf(1), 34);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule